// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter. It controls an external sample/hold switch and presents a trial code to a resistor-ladder tap selector. After each trial it reads back one comparator bit, and it resolves the result from the most significant bit down to the least. Software-facing control arrives as plain level inputs: a comparator enable, a run bit, a channel select and a 5-bit conversion-time field.

After the comparator is enabled, the block waits a settling time. While the run bit stays high it then converts back to back. Each finished result goes into two views, a left-justified 16-bit word and a truncated 8-bit byte, and a one-cycle end-of-conversion pulse is raised with it. If the run bit is cleared, the conversion in flight is dropped. If the channel select changes during a conversion, the block starts over on the new input.

Top module: `sar_seq`

## Requirements
- R1: After reset `sh_sample`, `dac_code`, `res16`, `res8` and `eoc_irq` are all zero, and `mux_sel` is zero.
- R2: No sampling phase begins until `cmp_en` has been high for more than SETTLE_CYC clocks. A run request made earlier is held and starts the conversion once that count has elapsed. Dropping `cmp_en` returns the block to idle.
- R3: Every conversion opens with `sh_sample` = 1 for 2*(tsel+1) clocks. `sh_sample` then stays 0 (hold) through all ten comparisons.
- R4: The first trial code is 0x200. Each trial sets the bit under test to 1. That bit stays 1 when `cmp_in` = 1 (input at or above the tap) and is cleared otherwise. The second trial is therefore 0x300 for a full-scale input and 0x100 for a zero input.
- R5: Each comparison lasts tsel+1 clocks. With `run` held high, successive end-of-conversion pulses are exactly 12*(tsel+1) clocks apart.
- R6: `res16` holds the 10-bit result in bits 15:6 with bits 5:0 zero, and `res8` holds result bits 9:2. Both change only when a conversion completes.
- R7: `eoc_irq` is high for exactly one clock, in the same cycle the new result first appears on `res16`/`res8`.
- R8: Clearing `run` mid-conversion abandons it. The block goes idle with no `eoc_irq` and no change to the results.
- R9: A change of `chan_sel` during a conversion updates `mux_sel` and restarts the sampling phase on the next clock. The next result then comes from the new channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_en | input | 1 | Comparator enable |
| run | input | 1 | Start/continue conversions while high |
| chan_sel | input | CH_W | Requested analog channel |
| tsel | input | 5 | Conversion-time select; step length tsel+1 clocks |
| cmp_in | input | 1 | Comparator result, 1 when input >= tap |
| sh_sample | output | 1 | 1 = sample, 0 = hold |
| dac_code | output | 10 | Trial code for the tap selector |
| mux_sel | output | CH_W | Channel currently routed to the sample/hold |
| res16 | output | 16 | Left-justified 10-bit result |
| res8 | output | 8 | Upper 8 result bits |
| eoc_irq | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The comparator is modelled against a per-channel digital level, so each result must reproduce that level exactly. The stimulus uses the values 0, 1023, 511, 512 and an alternating pattern. A sequencer with the keep/clear sense inverted, or one starting from the wrong trial, would report wrong codes, and so would one that loses the least significant step. The bench measures the settling hold-off, the sampling length and the spacing between back-to-back pulses, which catches an off-by-one in any counter. A mid-conversion stop must leave the results untouched with no pulse, and a channel switch must restart sampling and yield the new channel's value rather than a blend of the two.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int CH_W       = 2,
  parameter int SETTLE_CYC = 125
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmp_en,
  input  logic            run,
  input  logic [CH_W-1:0] chan_sel,
  input  logic [4:0]      tsel,
  input  logic            cmp_in,
  output logic            sh_sample,
  output logic [9:0]      dac_code,
  output logic [CH_W-1:0] mux_sel,
  output logic [15:0]     res16,
  output logic [7:0]      res8,
  output logic            eoc_irq
);
  localparam int ST_W = $clog2(SETTLE_CYC + 1);

  typedef enum logic [1:0] {IDLE, SAMP, CONV} st_t;

  st_t             st_q;
  logic [ST_W-1:0] settle_q;
  logic [6:0]      cnt_q;
  logic [3:0]      bit_q;
  logic [9:0]      sar_q;
  logic [9:0]      res_q;

  wire        ready    = settle_q == ST_W'(SETTLE_CYC);
  wire [5:0]  step_len = {1'b0, tsel} + 6'd1;
  wire [6:0]  cnt_lim  = (st_q == SAMP) ? {step_len, 1'b0} - 7'd1 : {1'b0, step_len} - 7'd1;
  wire        last     = cnt_q == cnt_lim;
  wire        chan_chg = chan_sel != mux_sel;
  wire [9:0]  bit_mask = 10'd1 << bit_q;
  wire [9:0]  resolved = cmp_in ? sar_q : (sar_q & ~bit_mask);

  assign sh_sample = st_q == SAMP;
  assign dac_code  = sar_q;
  assign res16     = {res_q, 6'b0};
  assign res8      = res_q[9:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          settle_q <= '0;
    else if (!cmp_en)    settle_q <= '0;
    else if (!ready)     settle_q <= settle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sar_q   <= '0;
      res_q   <= '0;
      mux_sel <= '0;
      eoc_irq <= 1'b0;
    end else begin
      eoc_irq <= 1'b0;
      if (st_q == IDLE) begin
        mux_sel <= chan_sel;
        if (run && ready) begin
          st_q  <= SAMP;
          cnt_q <= '0;
          sar_q <= '0;
        end
      end else if (!run || !cmp_en) begin
        st_q  <= IDLE;
        sar_q <= '0;
      end else if (chan_chg) begin
        mux_sel <= chan_sel;
        st_q    <= SAMP;
        cnt_q   <= '0;
        sar_q   <= '0;
      end else if (!last) begin
        cnt_q <= cnt_q + 7'd1;
      end else if (st_q == SAMP) begin
        st_q  <= CONV;
        cnt_q <= '0;
        bit_q <= 4'd9;
        sar_q <= 10'h200;
      end else begin
        cnt_q <= '0;
        if (bit_q == 4'd0) begin
          res_q   <= resolved;
          eoc_irq <= 1'b1;
          st_q    <= SAMP;
          sar_q   <= '0;
        end else begin
          sar_q <= resolved | (10'd1 << (bit_q - 4'd1));
          bit_q <= bit_q - 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmp_en,
  input logic        run,
  input logic        sh_sample,
  input logic        eoc_irq,
  input logic [15:0] res16,
  input logic [7:0]  res8
);
  // R7
  eoc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |=> !eoc_irq);

  // R6
  res_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res16[5:0] == 6'd0);

  // R6
  res_views_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res8 == res16[15:8]);

  // R6
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_irq |-> $stable(res16));

  // R8
  run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sh_sample);

  // R2
  sample_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_sample) |-> $past(cmp_en) && $past(run));
endmodule

bind sar_seq sar_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .run(run),
  .sh_sample(sh_sample), .eoc_irq(eoc_irq), .res16(res16), .res8(res8)
);

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
  localparam int CH_W   = 2;
  localparam int SETTLE = 20;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            cmp_en = 0;
  logic            run = 0;
  logic [CH_W-1:0] chan_sel = '0;
  logic [4:0]      tsel = 5'd1;
  logic            cmp_in;
  logic            sh_sample;
  logic [9:0]      dac_code;
  logic [CH_W-1:0] mux_sel;
  logic [15:0]     res16;
  logic [7:0]      res8;
  logic            eoc_irq;

  logic [9:0] chv [4];
  logic [9:0] q [$];
  int checks = 0, fails = 0, cyc = 0, prev_eoc = 0, last_eoc = 0;
  bit done = 0;

  sar_seq #(.CH_W(CH_W), .SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .run(run), .chan_sel(chan_sel),
    .tsel(tsel), .cmp_in(cmp_in), .sh_sample(sh_sample), .dac_code(dac_code),
    .mux_sel(mux_sel), .res16(res16), .res8(res8), .eoc_irq(eoc_irq)
  );

  assign cmp_in = chv[mux_sel] >= dac_code;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && eoc_irq) begin
      prev_eoc = last_eoc;
      last_eoc = cyc;
      if (q.size() == 0) begin
        chk(0, "R8", "unexpected eoc_irq", 1, 0);
      end else begin
        logic [9:0] e;
        e = q.pop_front();
        chk(res16 == {e, 6'b0}, "R4", "res16", res16, {e, 6'b0});
        chk(res8 == e[9:2], "R6", "res8", res8, e[9:2]);
      end
    end
  end

  task automatic drain_and_stop();
    while (q.size() != 0) @(negedge clk);
    run = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic trial_conv(input logic [9:0] v, input logic [9:0] second);
    int n;
    chv[chan_sel] = v;
    q.push_back(v);
    run = 1;
    @(negedge clk);
    while (!sh_sample) @(negedge clk);
    n = 0;
    while (sh_sample) begin n++; @(negedge clk); end
    chk(n == 2 * (tsel + 1), "R3", "sample length", n, 2 * (tsel + 1));
    chk(dac_code == 10'h200, "R4", "first trial", dac_code, 10'h200);
    repeat (tsel + 1) @(negedge clk);
    chk(dac_code == second, "R4", "second trial", dac_code, second);
    chk(!sh_sample, "R3", "hold during compare", sh_sample, 0);
    drain_and_stop();
  endtask

  initial begin
    int t0, d;
    logic [15:0] keep;
    for (int i = 0; i < 4; i++) chv[i] = '0;
    repeat (3) @(negedge clk);
    chk(res16 == 0 && res8 == 0 && !eoc_irq && !sh_sample && dac_code == 0 && mux_sel == 0,
        "R1", "reset state", {res16, res8}, 0);
    rst_n = 1;
    @(negedge clk);

    chv[0] = 10'h155;
    q.push_back(10'h155);
    run = 1;
    repeat (3) @(negedge clk);
    chk(!sh_sample, "R2", "no sample while comparator off", sh_sample, 0);
    cmp_en = 1;
    t0 = cyc;
    while (!sh_sample) @(negedge clk);
    d = cyc - t0;
    chk(d > SETTLE && d <= SETTLE + 2, "R2", "settling hold-off", d, SETTLE + 1);
    drain_and_stop();

    tsel = 5'd1;
    trial_conv(10'h3FF, 10'h300);
    trial_conv(10'h000, 10'h100);
    trial_conv(10'h1FF, 10'h100);
    trial_conv(10'h200, 10'h300);

    tsel = 5'd3;
    chv[0] = 10'h2AA;
    q.push_back(10'h2AA);
    q.push_back(10'h2AA);
    run = 1;
    while (q.size() != 0) @(negedge clk);
    d = last_eoc - prev_eoc;
    chk(d == 12 * (tsel + 1), "R5", "back-to-back spacing", d, 12 * (tsel + 1));
    run = 0;
    repeat (4) @(negedge clk);

    keep = res16;
    tsel = 5'd1;
    run = 1;
    repeat (10) @(negedge clk);
    run = 0;
    repeat (80) @(negedge clk);
    chk(res16 == keep, "R8", "result after abort", res16, keep);
    chk(!sh_sample, "R8", "idle after abort", sh_sample, 0);

    chv[0] = 10'd100;
    chv[2] = 10'd900;
    chan_sel = 2'd0;
    @(negedge clk);
    q.push_back(10'd900);
    run = 1;
    repeat (8) @(negedge clk);
    chan_sel = 2'd2;
    @(negedge clk);
    chk(mux_sel == 2'd2, "R9", "mux_sel follows", mux_sel, 2);
    chk(sh_sample && dac_code == 0, "R9", "restart sampling", sh_sample, 1);
    drain_and_stop();

    run = 1;
    repeat (6) @(negedge clk);
    cmp_en = 0;
    @(negedge clk);
    chk(!sh_sample, "R2", "comparator off stops", sh_sample, 0);
    run = 0;
    repeat (40) @(negedge clk);
    chk(q.size() == 0, "R7", "scoreboard drained", q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule